// File: doc/BRIEF.md
# Shared-Line Trigger-Mode Request Latch

This block sits at the input side of an eight-line interrupt controller. It turns per-line assert, deassert and pulse events into request bits. Each line keeps a count of the sources that currently hold it active, so several sources can share one line in a wired fashion. A per-line trigger-mode register picks edge or level behaviour. Edge lines latch a request on the first assertion and drop it only when the interrupt is acknowledged. Level lines keep the request up while any source holds the line and drop it when the last source lets go.

Each line is handled by a small state machine with two states. `LN_IDLE` means no source is holding the line. `LN_ACTIVE` means at least one source is holding it. Three transitions connect them. *First assert* goes from `LN_IDLE` to `LN_ACTIVE`. *Last deassert* goes from `LN_ACTIVE` back to `LN_IDLE`. *Hold* keeps `LN_ACTIVE` while the count changes but stays above zero. Any other event leaves the state where it is.

In each cycle, the events on a line are reduced to one operation: none, up, down or pulse. Acknowledge, mode writes and events all land on the next rising clock edge. While the controller reports that it is not initialised, line events are dropped.

Top module: `shared_line_req_latch`

## Requirements
- R1: After reset, the outputs read as follows: all request bits 0, all mode bits 0 (edge), all busy bits 0 and all underflow flags 0.
- R2: For each line, an assert adds one to the line's count and a deassert takes one away. The count saturates at 2^CNT_W-1 (15 by default). busy_o[i] is 1 exactly when the count of line i is above zero.
- R3: An assert that moves a line's count from 0 to 1 sets its request bit, in either trigger mode.
- R4: On a level line, any assert or deassert that leaves the count above zero sets the request bit.
- R5: A deassert that moves the count from 1 to 0 clears the request bit of a level line. On an edge line it leaves the request bit as it was.
- R6: On an edge line, a count change other than 0 to 1 leaves the request bit unchanged.
- R7: Acknowledge is given by ack_valid=1 with the line index on ack_line. It clears that line's request bit if the line is edge-triggered and has no effect on a level line. The acknowledge is applied before any event on the same line in the same cycle.
- R8: A pulse behaves as an assert followed at once by a deassert, and the count ends where it started. The effect on the request bit depends on the count and the mode:
  - Count 0, edge line: the request bit is set.
  - Count 0, level line: the request bit is left at 0.
  - Count above 0, level line: the request bit is set.
  - Count above 0, edge line: the request bit is unchanged.
  A pulse overrides any assert or deassert on the same line in the same cycle.
- R9: A write with mode_wr=1 loads mode_wdata into the trigger-mode register, where bit i=1 means line i is level-triggered. Bits set in FORCE_EDGE are stored as 0; the default is 0x07, which forces lines 0, 1 and 2 to edge. The new mode is visible on mode_o after the next edge and governs events from the following cycle onward.
- R10: While ctrl_ready=0, assert, deassert and pulse events change neither count, request bit nor underflow flag. Acknowledge and mode writes still act.
- R11: A deassert on a line whose count is 0 leaves the count at 0 and leaves the request bit unchanged. It sets that line's underflow flag, which stays set until reset.
- R12: An assert and a deassert on the same line in the same cycle, without a pulse, cancel. The count and the request bit are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_ready | input | 1 | Controller initialised; line events are dropped while 0 |
| evt_assert | input | NUM_LINES | Per-line assert event |
| evt_deassert | input | NUM_LINES | Per-line deassert event |
| evt_pulse | input | NUM_LINES | Per-line pulse event |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_line | input | $clog2(NUM_LINES) | Index of the acknowledged line |
| mode_wr | input | 1 | Trigger-mode register write strobe |
| mode_wdata | input | NUM_LINES | Trigger-mode write data, 1 = level |
| req_o | output | NUM_LINES | Request bits |
| mode_o | output | NUM_LINES | Stored trigger modes |
| busy_o | output | NUM_LINES | Line count above zero |
| underflow_o | output | NUM_LINES | Sticky per-line underflow flags |

## Verification
Directed sequences cover both trigger modes:
- Single and stacked asserts separate the first-assert rule from the level-hold rule.
- Stacked deasserts show that an edge request survives the last deassert while a level request falls.
- Acknowledges on each kind of line show the different clearing mechanisms.
- Pulses from a count of zero and from a non-zero count tell the four pulse outcomes apart.
- Counter saturation, cancelled assert/deassert pairs, and events while not ready show that the count is held.
- An acknowledge in the same cycle as a first assert fixes the order of the two.

A long mixed run with sparse random events, acknowledges and mode writes is then compared every cycle against a behavioural model.

// File: rtl/trig_latch_pkg.sv
package trig_latch_pkg;

    // Per-line occupancy state
    typedef enum logic [0:0] {
        LN_IDLE   = 1'b0,
        LN_ACTIVE = 1'b1
    } line_state_e;

    // Operation a line performs in one cycle after event reduction
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_UP    = 2'd1,
        OP_DOWN  = 2'd2,
        OP_PULSE = 2'd3
    } line_op_e;

endpackage

// File: rtl/trig_mode_reg.sv
module trig_mode_reg #(
    parameter int                   NUM_LINES  = 8,
    parameter logic [NUM_LINES-1:0] FORCE_EDGE = NUM_LINES'(7)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [NUM_LINES-1:0] wdata_i,
    output logic [NUM_LINES-1:0] mode_o
);

    localparam logic [NUM_LINES-1:0] WRITE_MASK = ~FORCE_EDGE;

    logic [NUM_LINES-1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_i) begin
            mode_q <= wdata_i & WRITE_MASK;
        end
    end

    assign mode_o = mode_q;

    AST_FORCED_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q & FORCE_EDGE) == '0); // R9

    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mode_q)); // R9

endmodule

// File: rtl/ack_decode.sv
module ack_decode #(
    parameter int NUM_LINES = 8,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic [IDX_W-1:0]     line_i,
    output logic [NUM_LINES-1:0] hit_o
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_hit
        assign hit_o[g] = valid_i && (line_i == IDX_W'(g));
    end

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_o)); // R7

    AST_ACK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> (hit_o == '0)); // R7

endmodule

// File: rtl/line_channel.sv
module line_channel
    import trig_latch_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic up_i,
    input  logic down_i,
    input  logic pulse_i,
    input  logic level_i,
    input  logic ack_i,
    output logic req_o,
    output logic busy_o,
    output logic uflow_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    line_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             req_q, req_d;
    logic             uflow_q, uflow_d;
    line_op_e         op;
    logic             req_keep;

    // Reduce the raw events of this cycle to one operation
    always_comb begin
        op = OP_NONE;
        if (en_i) begin
            if (pulse_i) begin
                op = OP_PULSE;
            end else if (up_i && !down_i) begin
                op = OP_UP;
            end else if (down_i && !up_i) begin
                op = OP_DOWN;
            end
        end
    end

    // Acknowledge acts first and only on edge lines
    assign req_keep = (ack_i && !level_i) ? 1'b0 : req_q;

    // Next-state and next-request logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        req_d   = req_keep;
        uflow_d = uflow_q;
        unique case (state_q)
            LN_IDLE: begin
                case (op)
                    OP_UP: begin
                        state_d = LN_ACTIVE;       // first assert
                        cnt_d   = CNT_ONE;
                        req_d   = 1'b1;
                    end
                    OP_DOWN: begin
                        uflow_d = 1'b1;            // deassert with nobody holding
                    end
                    OP_PULSE: begin
                        req_d = !level_i;          // level: set then cleared
                    end
                    default: ;
                endcase
            end
            LN_ACTIVE: begin
                case (op)
                    OP_UP: begin
                        if (cnt_q != CNT_MAX) begin
                            cnt_d = cnt_q + CNT_ONE;
                        end
                        req_d = level_i | req_keep;
                    end
                    OP_DOWN: begin
                        cnt_d = cnt_q - CNT_ONE;
                        if (cnt_q == CNT_ONE) begin
                            state_d = LN_IDLE;     // last deassert
                            req_d   = level_i ? 1'b0 : req_keep;
                        end else begin
                            req_d = level_i | req_keep;
                        end
                    end
                    OP_PULSE: begin
                        req_d = level_i | req_keep;
                    end
                    default: ;
                endcase
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            cnt_q   <= '0;
            req_q   <= 1'b0;
            uflow_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            req_q   <= req_d;
            uflow_q <= uflow_d;
        end
    end

    // Outputs
    always_comb begin
        req_o   = req_q;
        busy_o  = (state_q == LN_ACTIVE);
        uflow_o = uflow_q;
    end

    AST_STATE_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_IDLE) == (cnt_q == '0)); // R2

    AST_FIRST_ASSERT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_IDLE && op == OP_UP) |=> req_q); // R3

    AST_LEVEL_LAST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_ACTIVE && cnt_q == CNT_ONE && op == OP_DOWN && level_i)
        |=> (!req_q && state_q == LN_IDLE)); // R5

    AST_LEVEL_ACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i && req_q && ack_i && op == OP_NONE) |=> req_q); // R7

    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(cnt_q) && $stable(uflow_q))); // R10

    AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_q |=> uflow_q); // R11

    AST_CANCEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && up_i && down_i && !pulse_i) |=> $stable(cnt_q)); // R12

endmodule

// File: rtl/shared_line_req_latch.sv
module shared_line_req_latch #(
    parameter int                   NUM_LINES  = 8,
    parameter int                   CNT_W      = 4,
    parameter logic [NUM_LINES-1:0] FORCE_EDGE = NUM_LINES'(7),
    localparam int                  IDX_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_ready,
    input  logic [NUM_LINES-1:0] evt_assert,
    input  logic [NUM_LINES-1:0] evt_deassert,
    input  logic [NUM_LINES-1:0] evt_pulse,
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_line,
    input  logic                 mode_wr,
    input  logic [NUM_LINES-1:0] mode_wdata,
    output logic [NUM_LINES-1:0] req_o,
    output logic [NUM_LINES-1:0] mode_o,
    output logic [NUM_LINES-1:0] busy_o,
    output logic [NUM_LINES-1:0] underflow_o
);

    logic [NUM_LINES-1:0] level_mode;
    logic [NUM_LINES-1:0] ack_hit;

    trig_mode_reg #(
        .NUM_LINES  (NUM_LINES),
        .FORCE_EDGE (FORCE_EDGE)
    ) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mode_wr),
        .wdata_i (mode_wdata),
        .mode_o  (level_mode)
    );

    ack_decode #(
        .NUM_LINES (NUM_LINES)
    ) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (ack_valid),
        .line_i  (ack_line),
        .hit_o   (ack_hit)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (ctrl_ready),
            .up_i    (evt_assert[g]),
            .down_i  (evt_deassert[g]),
            .pulse_i (evt_pulse[g]),
            .level_i (level_mode[g]),
            .ack_i   (ack_hit[g]),
            .req_o   (req_o[g]),
            .busy_o  (busy_o[g]),
            .uflow_o (underflow_o[g])
        );
    end

    assign mode_o = level_mode;

    AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ctrl_ready && ((level_mode >> ack_line) & 1) == 0)
        |=> ((req_o >> $past(ack_line)) & 1) == 0); // R7

    AST_NOT_READY_REQ_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_ready && !ack_valid) |=> $stable(req_o)); // R10

endmodule

// File: tb/test_shared_line_req_latch.sv
`timescale 1ns/1ps
module test_shared_line_req_latch;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctrl_ready = 1'b0;
    logic [N-1:0] evt_assert = '0;
    logic [N-1:0] evt_deassert = '0;
    logic [N-1:0] evt_pulse = '0;
    logic         ack_valid = 1'b0;
    logic [2:0]   ack_line = '0;
    logic         mode_wr = 1'b0;
    logic [N-1:0] mode_wdata = '0;
    logic [N-1:0] req_o, mode_o, busy_o, underflow_o;

    always #2 clk = ~clk;  // 250 MHz

    shared_line_req_latch i_shared_line_req_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_ready  (ctrl_ready),
        .evt_assert  (evt_assert),
        .evt_deassert(evt_deassert),
        .evt_pulse   (evt_pulse),
        .ack_valid   (ack_valid),
        .ack_line    (ack_line),
        .mode_wr     (mode_wr),
        .mode_wdata  (mode_wdata),
        .req_o       (req_o),
        .mode_o      (mode_o),
        .busy_o      (busy_o),
        .underflow_o (underflow_o)
    );

    // Behavioural reference model
    int           m_cnt [N];
    logic [N-1:0] m_req, m_mode, m_uf;
    bit           started = 0;
    bit           done = 0;
    int           n_chk = 0;
    int           n_fail = 0;
    string        phase = "R1";

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_cnt[i] = 0;
            m_req  = '0;
            m_mode = '0;
            m_uf   = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (ack_valid && (int'(ack_line) == i) && !m_mode[i]) m_req[i] = 1'b0;
                if (ctrl_ready) begin
                    if (evt_pulse[i]) begin
                        if (m_cnt[i] == 0) m_req[i] = !m_mode[i];
                        else if (m_mode[i]) m_req[i] = 1'b1;
                    end else if (evt_assert[i] && !evt_deassert[i]) begin
                        if (m_cnt[i] == 0 || m_mode[i]) m_req[i] = 1'b1;
                        if (m_cnt[i] < 15) m_cnt[i] = m_cnt[i] + 1;
                    end else if (evt_deassert[i] && !evt_assert[i]) begin
                        if (m_cnt[i] == 0) begin
                            m_uf[i] = 1'b1;
                        end else begin
                            m_cnt[i] = m_cnt[i] - 1;
                            if (m_cnt[i] == 0) begin
                                if (m_mode[i]) m_req[i] = 1'b0;
                            end else if (m_mode[i]) begin
                                m_req[i] = 1'b1;
                            end
                        end
                    end
                end
            end
            if (mode_wr) m_mode = mode_wdata & 8'hF8;
        end
    end

    task automatic chk(input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            logic [N-1:0] exp_busy;
            for (int i = 0; i < N; i++) exp_busy[i] = (m_cnt[i] > 0);
            chk("req_o", req_o, m_req);
            chk("mode_o", mode_o, m_mode);
            chk("busy_o", busy_o, exp_busy);
            chk("underflow_o", underflow_o, m_uf);
        end
    end

    task automatic put(input logic [N-1:0] a, input logic [N-1:0] d, input logic [N-1:0] p,
                       input logic av, input logic [2:0] al,
                       input logic mw, input logic [N-1:0] md);
        @(negedge clk);
        evt_assert   = a;
        evt_deassert = d;
        evt_pulse    = p;
        ack_valid    = av;
        ack_line     = al;
        mode_wr      = mw;
        mode_wdata   = md;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) put('0, '0, '0, 1'b0, 3'd0, 1'b0, '0);
    endtask

    task automatic finish_run;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        ctrl_ready = 1'b1;

        // R9: forced-edge bits
        phase = "R9";
        put('0, '0, '0, 0, 0, 1, 8'hFF);
        idle(2);

        // R3, R6, R5, R7 on edge line 0
        phase = "R3";  put(8'h01, '0, '0, 0, 0, 0, '0);
        phase = "R6";  put(8'h01, '0, '0, 0, 0, 0, '0);
        put('0, 8'h01, '0, 0, 0, 0, '0);
        phase = "R5";  put('0, 8'h01, '0, 0, 0, 0, '0);
        idle(1);
        phase = "R7";  put('0, '0, '0, 1, 3'd0, 0, '0);
        idle(1);

        // R4, R7, R5 on level line 3
        phase = "R4";  put(8'h08, '0, '0, 0, 0, 0, '0);
        put(8'h08, '0, '0, 0, 0, 0, '0);
        phase = "R7";  put('0, '0, '0, 1, 3'd3, 0, '0);
        phase = "R4";  put('0, 8'h08, '0, 0, 0, 0, '0);
        phase = "R5";  put('0, 8'h08, '0, 0, 0, 0, '0);
        idle(1);

        // R12: cancel on line 5
        phase = "R12"; put(8'h20, 8'h20, '0, 0, 0, 0, '0);
        idle(1);

        // R11: underflow on line 6, then normal use
        phase = "R11"; put('0, 8'h40, '0, 0, 0, 0, '0);
        idle(1);
        put(8'h40, '0, '0, 0, 0, 0, '0);
        put('0, 8'h40, '0, 0, 0, 0, '0);
        idle(1);

        // R8: pulses from zero on edge line 1 and level line 4
        phase = "R8";  put('0, '0, 8'h12, 0, 0, 0, '0);
        idle(1);
        // edge line 2 held, acked, then pulsed: stays clear
        put(8'h04, '0, '0, 0, 0, 0, '0);
        put('0, '0, '0, 1, 3'd2, 0, '0);
        put('0, '0, 8'h04, 0, 0, 0, '0);
        // pulse overriding assert and deassert
        put(8'h04, 8'h80, 8'h84, 0, 0, 0, '0);
        // level line 7 held, pulsed
        put(8'h80, '0, '0, 0, 0, 0, '0);
        put('0, '0, 8'h80, 0, 0, 0, '0);
        idle(1);

        // R2: saturation on line 1
        phase = "R2";
        for (int k = 0; k < 17; k++) put(8'h02, '0, '0, 0, 0, 0, '0);
        for (int k = 0; k < 16; k++) put('0, 8'h02, '0, 0, 0, 0, '0);
        idle(1);

        // R10: events dropped while not ready, ack and mode write still act
        phase = "R10";
        ctrl_ready = 1'b0;
        put(8'hFF, '0, '0, 0, 0, 0, '0);
        put('0, '0, 8'hFF, 0, 0, 0, '0);
        put('0, 8'hFF, '0, 0, 0, 0, '0);
        put('0, '0, '0, 1, 3'd2, 0, '0);
        put('0, '0, '0, 0, 0, 1, 8'h00);
        idle(2);
        ctrl_ready = 1'b1;
        put('0, '0, '0, 0, 0, 1, 8'hF0);
        idle(1);

        // R7: ack in same cycle as first assert on edge line 0
        phase = "R7";
        put('0, '0, '0, 1, 3'd0, 0, '0);
        put(8'h01, '0, '0, 1, 3'd0, 0, '0);
        idle(2);

        // Mixed run against the model
        phase = "R4 mix";
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] a, d, p;
            a = 8'($urandom) & 8'($urandom);
            d = 8'($urandom) & 8'($urandom);
            p = 8'($urandom) & 8'($urandom) & 8'($urandom);
            put(a, d, p, 1'($urandom), 3'($urandom), (($urandom % 64) == 0), 8'($urandom));
        end
        idle(2);
        finish_run();
    end

endmodule